// File: doc/BRIEF.md
# FEC-Aware Rate Adaptation FIFO

This block sits between the source of transmit codes and the 64b/66b encoder of a burst-mode upstream transmitter. Each code is one byte plus a control flag. While the FEC encoder emits parity it raises a pause input. During the pause the block sends nothing downstream and stores the codes that keep arriving. When the pause ends, the stored backlog is sent from the head, one code per cycle, while new codes keep joining at the tail.

To let the backlog shrink, the block discards every arriving idle code while it holds at least one stored code. When it is empty and not paused, an arriving code passes straight through in the same cycle. The block reports an empty flag, which the FEC encoder checks before it turns the laser off. The synchronous reset is pulsed at the start of every upstream burst. A sticky flag records any code that was lost because the store was full.

Top module: `rate_adapt_fifo`

## Requirements
- R1: After reset, `buf_empty` is 1, `lost_code` is 0, and `out_valid` is 0 while no code arrives and no pause is requested.
- R2: While `fec_pause` is 1, `out_valid` is 0. Every arriving code that is not discarded under R4 is stored at the tail.
- R3: When `fec_pause` returns to 0, stored codes leave in arrival order, starting with the oldest.
- R4: An arriving idle code (control flag 1, byte 0x07) is discarded when the store holds at least one code at its arrival, whether or not a pause is active.
- R5: When the store is empty and `fec_pause` is 0, the arriving code appears on the output in the same cycle, idle codes included, and nothing is stored.
- R6: When the store is non-empty and `fec_pause` is 0, the head code is output with `out_valid` 1 in every cycle. A non-idle code that arrives in that cycle is stored at the same time, so the occupancy stays constant.
- R7: `buf_empty` is 1 exactly when the store holds no code.
- R8: If a code must be stored while the store is full and no code leaves in that cycle, the code is lost and `lost_code` goes to 1. It stays 1 until reset.
- R9: Reset clears the stored backlog and `lost_code`, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, pulsed at each burst start |
| in_valid | input | 1 | A code is offered this cycle |
| in_byte | input | 8 | Arriving code byte |
| in_ctrl | input | 1 | Arriving code control flag |
| fec_pause | input | 1 | Parity insertion active; holds the output |
| out_valid | output | 1 | A code is presented to the encoder |
| out_byte | output | 8 | Outgoing code byte |
| out_ctrl | output | 1 | Outgoing code control flag |
| buf_empty | output | 1 | Store holds no code |
| lost_code | output | 1 | Sticky overflow indication |

## Verification
The embedded assertions check on every cycle that the output is silent during a pause, that the loss flag never falls, that occupancy stays in range with no read from an empty store, that an idle arriving at a paused, non-empty store leaves the occupancy unchanged, and that the empty, unpaused state is not left by a single arrival. Only the bench scenarios can show that codes leave in order after a pause and that backlogs drain through idle removal. The bench also shows the exact loss point when the store is full and that a mid-backlog reset clears the block.

// File: rtl/rate_adapt_pkg.sv
// Package: shared code type and idle detection for the rate adaptation FIFO.
// Assumes the idle code is the control character 0x07.
package rate_adapt_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h07;

    typedef struct packed {
        logic              ctrl;
        logic [BYTE_W-1:0] data;
    } xcode_t;

    localparam int CODE_W = $bits(xcode_t);

    // True when the code is the idle control character.
    function automatic logic is_idle(input xcode_t c);
        return c.ctrl && (c.data == IDLE_BYTE);
    endfunction

endpackage

// File: rtl/ra_store.sv
// Module: ra_store
// Circular code store with head/tail pointers and an occupancy count.
// Assumes the caller never pushes into a full store unless it pops in the
// same cycle, and never pops an empty store. DEPTH need not be a power of two.
module ra_store
    import rate_adapt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  xcode_t        wr_code,
    output xcode_t        head_code,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    xcode_t        mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign empty     = (occ == '0);
    assign full      = (occ == CAP);
    assign head_code = mem[rd_ptr];

    // Write the arriving code into the slot at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_code;
        end
    end

    // Advance the pointers and the occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // R7: occupancy never exceeds the capacity.
    p_occ_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CAP);

    // R6: the head is never read from an empty store.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8: a push into a full store only happens together with a pop.
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

endmodule

// File: rtl/ra_steer.sv
// Module: ra_steer
// Per-cycle steering: decides on bypass, pop, push, idle discard and loss,
// and selects the output code. It is purely combinational.
// Assumes the store status reflects the occupancy at the start of the cycle.
module ra_steer
    import rate_adapt_pkg::*;
(
    input  logic   in_valid,
    input  xcode_t in_code,
    input  logic   pause,
    input  logic   st_empty,
    input  logic   st_full,
    input  xcode_t st_head,
    output logic   push,
    output logic   pop,
    output logic   loss,
    output logic   o_valid,
    output xcode_t o_code
);

    logic drop;
    logic bypass;
    logic want_store;

    // Classify the arriving code and the store action for this cycle.
    always_comb begin
        drop       = in_valid && is_idle(in_code) && !st_empty;
        bypass     = !pause && st_empty;
        pop        = !pause && !st_empty;
        want_store = in_valid && !drop && !bypass;
        push       = want_store && (!st_full || pop);
        loss       = want_store && st_full && !pop;
    end

    // Choose between the live code and the stored head for the output.
    always_comb begin
        if (bypass) begin
            o_valid = in_valid;
            o_code  = in_code;
        end else begin
            o_valid = pop;
            o_code  = st_head;
        end
    end

endmodule

// File: rtl/rate_adapt_fifo.sv
// Module: rate_adapt_fifo (top)
// Code FIFO in front of the 64b/66b encoder. It holds the output while FEC
// parity is inserted, discards idles while it has a backlog, and reports
// when it is empty. Assumes rst_n is pulsed at each burst start.
module rate_adapt_fifo
    import rate_adapt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_ctrl,
    input  logic       fec_pause,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_ctrl,
    output logic       buf_empty,
    output logic       lost_code
);

    localparam int CW = $clog2(DEPTH + 1);

    xcode_t        in_code;
    xcode_t        head;
    xcode_t        o_code;
    logic          push;
    logic          pop;
    logic          loss;
    logic          st_full;
    logic          st_empty;
    logic [CW-1:0] occ;

    assign in_code = '{ctrl: in_ctrl, data: in_byte};

    ra_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_code   (in_code),
        .head_code (head),
        .occ       (occ),
        .full      (st_full),
        .empty     (st_empty)
    );

    ra_steer u_steer (
        .in_valid (in_valid),
        .in_code  (in_code),
        .pause    (fec_pause),
        .st_empty (st_empty),
        .st_full  (st_full),
        .st_head  (head),
        .push     (push),
        .pop      (pop),
        .loss     (loss),
        .o_valid  (out_valid),
        .o_code   (o_code)
    );

    assign out_byte  = o_code.data;
    assign out_ctrl  = o_code.ctrl;
    assign buf_empty = st_empty;

    // Latch any lost code until the next burst reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lost_code <= 1'b0;
        else if (loss) lost_code <= 1'b1;
    end

    // R2: nothing leaves while parity is being inserted.
    p_pause_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fec_pause |-> !out_valid);

    // R8: the loss flag is sticky.
    p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_code |=> lost_code);

    // R4: an idle that reaches a paused, non-empty store leaves occupancy unchanged.
    p_idle_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fec_pause && !buf_empty && in_valid && in_ctrl && in_byte == IDLE_BYTE)
        |=> occ == $past(occ));

    // R5: an unpaused, empty store stays empty, because arrivals bypass it.
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && !fec_pause) |=> buf_empty);

endmodule

// File: tb/tb_rate_adapt_fifo.sv
// Bench for rate_adapt_fifo: a behavioural queue model compared on every clock.
module tb_rate_adapt_fifo;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ctrl = 1'b0;
    logic       fec_pause = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_ctrl;
    logic       buf_empty;
    logic       lost_code;

    int checks = 0;
    int errors = 0;
    logic [8:0] q[$];
    bit m_lost = 1'b0;

    always #2 clk = ~clk;

    rate_adapt_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ctrl(in_ctrl), .fec_pause(fec_pause), .out_valid(out_valid),
        .out_byte(out_byte), .out_ctrl(out_ctrl), .buf_empty(buf_empty),
        .lost_code(lost_code)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, then update the model.
    task automatic step(input string tag, input bit v, input bit c, input logic [7:0] b, input bit p);
        bit emp;
        bit ev;
        logic [8:0] ec;
        bit idle;
        in_valid = v; in_ctrl = c; in_byte = b; fec_pause = p;
        #1;
        emp = (q.size() == 0);
        ev = 1'b0; ec = '0;
        if (!p) begin
            if (emp) begin ev = v; ec = {c, b}; end
            else begin ev = 1'b1; ec = q[0]; end
        end
        chk(tag, "out_valid", out_valid, ev);
        if (ev) chk(tag, "out_code", {out_ctrl, out_byte}, ec);
        chk("R7", "buf_empty", buf_empty, emp);
        chk("R8", "lost_code", lost_code, m_lost);
        idle = c && (b == 8'h07);
        if (!p && !emp) void'(q.pop_front());
        if (v && !(idle && !emp) && !(!p && emp)) begin
            if (q.size() < DEPTH) q.push_back({c, b});
            else m_lost = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; fec_pause = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        q.delete(); m_lost = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state with no traffic.
        step("R1", 0, 0, 8'h00, 0);
        step("R1", 0, 0, 8'h00, 0);
        // R5: bypass when empty, data and idle alike.
        step("R5", 1, 0, 8'h11, 0);
        step("R5", 1, 1, 8'h07, 0);
        step("R5", 1, 1, 8'hFB, 0);
        // R2: pause stores arrivals; the first idle goes in while empty, later idles drop (R4).
        step("R2", 1, 1, 8'h07, 1);
        step("R2", 1, 0, 8'hA1, 1);
        step("R4", 1, 1, 8'h07, 1);
        step("R2", 1, 0, 8'hA2, 1);
        step("R2", 1, 0, 8'hA3, 1);
        // R3: resume from the head while idles arrive and are dropped.
        for (int i = 0; i < 6; i++) step("R3", 1, 1, 8'h07, 0);
        // R6: constant backlog under non-idle arrivals.
        step("R2", 1, 0, 8'hB0, 1);
        step("R2", 1, 0, 8'hB1, 1);
        for (int i = 0; i < 5; i++) step("R6", 1, 0, 8'hC0 + 8'(i), 0);
        for (int i = 0; i < 4; i++) step("R4", 1, 1, 8'h07, 0);
        // R8: overflow during a long pause.
        for (int i = 0; i < DEPTH + 3; i++) step("R8", 1, 0, 8'(i), 1);
        for (int i = 0; i < DEPTH + 2; i++) step("R8", 0, 0, 8'h00, 0);
        // R9: reset in the middle of a backlog.
        for (int i = 0; i < 5; i++) step("R9", 1, 0, 8'h50 + 8'(i), 1);
        do_reset();
        step("R9", 0, 0, 8'h00, 0);
        step("R9", 1, 0, 8'h66, 0);
        // R6: pseudo-random mix of pauses, idles and data.
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 99);
            bit pz = ($urandom_range(0, 3) == 0);
            if (r < 40) step("R6", 1, 1, 8'h07, pz);
            else if (r < 85) step("R6", 1, 0, 8'($urandom_range(0, 255)), pz);
            else step("R6", 0, 0, 8'h00, pz);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule